// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer with Page-Table Fallback

This block translates a 20-bit virtual address into an 18-bit physical address for a small memory management unit with 4 KB pages. It caches eight page translations, arranged as four sets of two ways. The set is picked by the two low bits of the virtual page number, and the remaining six bits of that page number are the tag. The 12-bit page offset is never used for the lookup and is copied straight into the result.

When a lookup hits, the answer comes back in the cycle after the request is accepted. When it misses, the block reads a single-level page table through a read port with a fixed latency of one cycle. It then answers from that entry and stores the translation in the cache when the entry is marked valid. An entry marked invalid produces a page-fault response and nothing is stored. A flush input empties the whole cache in one cycle. Only one request is in flight at a time.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no response is presented (`rsp_valid`=0), `req_ready` is 1 and no table read is issued (`pt_rd_en`=0). The cache starts empty, so the first lookup of any page misses.
- R2: A non-fault response has `rsp_pa[17:12]` equal to the page number found and `rsp_pa[11:0]` equal to `req_va[11:0]`.
- R3: The lookup uses set `req_va[13:12]` and tag `req_va[19:14]`. A hit raises `rsp_valid` in the cycle after acceptance, with `rsp_fault`=0, and issues no table read.
- R4: A miss pulses `pt_rd_en` for one cycle in the cycle after acceptance, with `pt_rd_idx` = `req_va[19:12]`. The table answers one cycle later on `pt_rd_present`/`pt_rd_ppn`, and the response follows one cycle after that, three cycles after acceptance.
- R5: A miss whose table entry has `pt_rd_present`=1 stores the translation, so the next request for the same page hits.
- R6: A miss whose table entry has `pt_rd_present`=0 responds with `rsp_fault`=1 and `rsp_pa`=0 and stores nothing. A repeat request for that page misses again.
- R7: A fill goes into an invalid way of the set when there is one. Otherwise it replaces the way of that set that was used least recently, where every hit and every fill counts as a use.
- R8: A `flush` pulse invalidates all entries in that cycle. No request is accepted in a cycle with `flush` high. A flush in the cycle where a fill would happen still lets the response out but blocks the fill.
- R9: `req_ready` stays 0 from the acceptance of a missing request until its response is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_va | input | 20 | Virtual address |
| rsp_valid | output | 1 | Response present (one cycle per request) |
| rsp_pa | output | 18 | Physical address |
| rsp_fault | output | 1 | Page-table entry was invalid |
| pt_rd_en | output | 1 | Page-table read strobe |
| pt_rd_idx | output | 8 | Page-table index (virtual page number) |
| pt_rd_present | input | 1 | Valid bit of the entry read, one cycle after the strobe |
| pt_rd_ppn | input | 6 | Physical page number of the entry read |

## Verification
The assertions check on every cycle that each accepted request takes exactly one path, either a hit response or a table read. They also check that a table read carries the page number just accepted and is followed two cycles later by a response with the original offset. Finally, they check that a read or a flush keeps `req_ready` low. Whether an entry was kept, replaced or dropped can only be seen by the bench's request sequences: which pages hit later, which miss, the behaviour after faults and the eviction order of the least-recently-used choice. The effect of a flush on the cache contents is seen the same way.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W     = 20,
  parameter int PA_W     = 18,
  parameter int OFF_W    = 12,
  parameter int SET_BITS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_va,
  output logic                    rsp_valid,
  output logic [PA_W-1:0]         rsp_pa,
  output logic                    rsp_fault,
  output logic                    pt_rd_en,
  output logic [VA_W-OFF_W-1:0]   pt_rd_idx,
  input  logic                    pt_rd_present,
  input  logic [PA_W-OFF_W-1:0]   pt_rd_ppn
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int TAG_W = VPN_W - SET_BITS;
  localparam int SETS  = 1 << SET_BITS;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_FILL} state_t;

  state_t              state_q;
  logic [VPN_W-1:0]    vpn_q;
  logic [OFF_W-1:0]    off_q;
  logic [1:0]          vld_q [SETS];
  logic [TAG_W-1:0]    tag_q [SETS][2];
  logic [PPN_W-1:0]    ppn_q [SETS][2];
  logic [SETS-1:0]     lru_q;

  logic                accept;
  logic [SET_BITS-1:0] set_in, set_f;
  logic [TAG_W-1:0]    tag_in;
  logic [1:0]          hit_w;
  logic                hit, hit_way, victim;

  assign req_ready = (state_q == S_IDLE) && !flush;
  assign accept    = req_valid && req_ready;
  assign set_in    = req_va[OFF_W +: SET_BITS];
  assign tag_in    = req_va[OFF_W+SET_BITS +: TAG_W];

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit_w[w] = vld_q[set_in][w] && (tag_q[set_in][w] == tag_in);
  end

  assign hit     = |hit_w;
  assign hit_way = hit_w[1];
  assign set_f   = vpn_q[SET_BITS-1:0];
  assign victim  = !vld_q[set_f][0] ? 1'b0 :
                   !vld_q[set_f][1] ? 1'b1 : lru_q[set_f];

  assign pt_rd_en  = (state_q == S_READ);
  assign pt_rd_idx = vpn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= 1'b0;
      vpn_q     <= '0;
      off_q     <= '0;
      lru_q     <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= 2'b00;
        for (int w = 0; w < 2; w++) begin
          tag_q[s][w] <= '0;
          ppn_q[s][w] <= '0;
        end
      end
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          vpn_q <= req_va[VA_W-1:OFF_W];
          off_q <= req_va[OFF_W-1:0];
          if (hit) begin
            rsp_valid      <= 1'b1;
            rsp_fault      <= 1'b0;
            rsp_pa         <= {ppn_q[set_in][hit_way], req_va[OFF_W-1:0]};
            lru_q[set_in]  <= ~hit_way;
          end else begin
            state_q <= S_READ;
          end
        end
        S_READ: state_q <= S_FILL;
        S_FILL: begin
          state_q   <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_fault <= !pt_rd_present;
          rsp_pa    <= pt_rd_present ? {pt_rd_ppn, off_q} : '0;
          if (pt_rd_present) begin
            vld_q[set_f][victim] <= 1'b1;
            tag_q[set_f][victim] <= vpn_q[VPN_W-1:SET_BITS];
            ppn_q[set_f][victim] <= pt_rd_ppn;
            lru_q[set_f]         <= ~victim;
          end
        end
        default: state_q <= S_IDLE;
      endcase
      if (flush) begin
        for (int s = 0; s < SETS; s++) vld_q[s] <= 2'b00;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W  = 20,
  parameter int PA_W  = 18,
  parameter int OFF_W = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [VA_W-1:0]       req_va,
  input logic                  rsp_valid,
  input logic [PA_W-1:0]       rsp_pa,
  input logic                  rsp_fault,
  input logic                  pt_rd_en,
  input logic [VA_W-OFF_W-1:0] pt_rd_idx
);
  logic acc;
  assign acc = req_valid && req_ready;

  a_r3_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ($countones({rsp_valid, pt_rd_en}) == 1));

  a_r4_read_index: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!pt_rd_en || pt_rd_idx == $past(req_va[VA_W-1:OFF_W])));

  a_r4_resp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rd_en |-> ##2 rsp_valid);

  a_r2_miss_offset: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rd_en |-> ##2 (rsp_fault || rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0], 3)));

  a_r2_hit_offset: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!rsp_valid || rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0])));

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rd_en |-> !req_ready);

  a_r8_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !req_ready);

  a_r6_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_pa == '0));
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
  .req_ready(req_ready), .req_va(req_va), .rsp_valid(rsp_valid),
  .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .pt_rd_en(pt_rd_en),
  .pt_rd_idx(pt_rd_idx)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic        clk = 0, rst_n = 0, flush = 0, req_valid = 0;
  logic [19:0] req_va = '0;
  logic        req_ready, rsp_valid, rsp_fault, pt_rd_en;
  logic [17:0] rsp_pa;
  logic [7:0]  pt_rd_idx;
  logic        pt_rd_present = 0;
  logic [5:0]  pt_rd_ppn = '0;
  int          checks = 0, errors = 0, reads = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_ready(req_ready), .req_va(req_va), .rsp_valid(rsp_valid),
    .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .pt_rd_en(pt_rd_en),
    .pt_rd_idx(pt_rd_idx), .pt_rd_present(pt_rd_present), .pt_rd_ppn(pt_rd_ppn)
  );

  function automatic logic pte_ok(input logic [7:0] v);
    return v[2:0] != 3'b110;
  endfunction

  function automatic logic [5:0] pte_ppn(input logic [7:0] v);
    if (v == 8'h14) return 6'h13;
    if (v == 8'h1F) return 6'h15;
    return 6'(v ^ 8'h2A);
  endfunction

  always @(posedge clk) begin
    if (pt_rd_en) begin
      pt_rd_present <= pte_ok(pt_rd_idx);
      pt_rd_ppn     <= pte_ppn(pt_rd_idx);
      reads         <= reads + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  localparam logic [19:0] VEC_VA [NV] = '{
    20'h14213, 20'h14213, 20'h1F213, 20'h1F000, 20'h1FFFF, 20'h06123, 20'h06123,
    20'h24ABC, 20'h14213, 20'h34000, 20'h14213, 20'h24ABC, 20'h34000, 20'h14213};
  localparam int VEC_LAT [NV] = '{3, 1, 3, 1, 1, 3, 3, 3, 1, 3, 1, 3, 3, 3};
  localparam string VEC_RQ [NV] = '{"R4", "R5", "R4", "R3", "R2", "R6", "R6",
    "R7", "R3", "R7", "R7", "R7", "R7", "R7"};

  task automatic xlate(input logic [19:0] va, input int exp_lat, input string rq);
    int lat = 0;
    int r0;
    logic [7:0] v = va[19:12];
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", req_ready, 1);
    r0 = reads;
    req_valid = 1; req_va = va;
    @(posedge clk);
    for (int n = 1; n <= 8; n++) begin
      @(negedge clk);
      req_valid = 0;
      if (rsp_valid) begin lat = n; break; end
      chk(req_ready == 1'b0, "R9", req_ready, 0);
    end
    chk(lat == exp_lat, rq, lat, exp_lat);
    chk(reads - r0 == (exp_lat == 1 ? 0 : 1), "R4", reads - r0, exp_lat == 1 ? 0 : 1);
    if (pte_ok(v)) begin
      chk(rsp_fault == 1'b0, "R6", rsp_fault, 0);
      chk(rsp_pa == {pte_ppn(v), va[11:0]}, "R2", rsp_pa, {pte_ppn(v), va[11:0]});
    end else begin
      chk(rsp_fault == 1'b1, "R6", rsp_fault, 1);
      chk(rsp_pa == 18'h0, "R6", rsp_pa, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 0, "R1", rsp_valid, 0);
    chk(pt_rd_en == 0, "R1", pt_rd_en, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1", req_ready, 1);
    chk(rsp_valid == 0, "R1", rsp_valid, 0);

    for (int i = 0; i < NV; i++) xlate(VEC_VA[i], VEC_LAT[i], VEC_RQ[i]);

    // R8: flush blocks acceptance and empties the cache
    @(negedge clk);
    flush = 1; req_valid = 1; req_va = 20'h1F213;
    #1 chk(req_ready == 0, "R8", req_ready, 0);
    @(negedge clk);
    flush = 0; req_valid = 0;
    chk(rsp_valid == 0 && pt_rd_en == 0, "R8", {rsp_valid, pt_rd_en}, 0);
    xlate(20'h1F213, 3, "R8");
    xlate(20'h14213, 3, "R8");
    xlate(20'h14213, 1, "R5");

    // R8: flush in the fill cycle keeps the response, blocks the fill
    @(negedge clk);
    req_valid = 1; req_va = 20'h2C000;
    @(negedge clk); req_valid = 0;
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    chk(rsp_valid == 1, "R8", rsp_valid, 1);
    chk(rsp_pa == {pte_ppn(8'h2C), 12'h000}, "R8", rsp_pa, {pte_ppn(8'h2C), 12'h000});
    xlate(20'h2C000, 3, "R8");
    xlate(20'h2C7A5, 1, "R5");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule